// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Ninth-Bit Address Filtering

This block recovers frames from an asynchronous serial line and queues them for software. The line is sampled on a 16x oversampling tick supplied from outside. A start bit has to still read low at mid-bit, so short low glitches never open a frame. Each data bit is taken as a three-sample majority around its centre. Frames carry eight or nine data bits, least significant bit first, followed by one stop bit.

Software drives the block through a two-address register port. A write to address 0 sets the control bits. A read of address 0 returns status. A read of address 1 returns the oldest received byte and removes it from a two-entry queue. In nine-bit mode the receiver can act as a node on a multi-drop bus. With address filtering on, only frames whose ninth bit is 1 are queued, and frames with the ninth bit at 0 are dropped without a trace. Each entry remembers whether its own stop bit was bad. When a frame finishes while the queue is full, an overrun flag latches, and the queue then takes nothing new until reception is switched off.

Top module: `uart_rx_addr`

## Requirements
- R1: After reset the control bits are 0, a status read (address 0) returns 0x00, and `rx_irq` is low.
- R2: Control bit 0 (port enable) at 0 holds the receiver idle, empties the queue and clears the overrun flag. No frame is received while it is 0.
- R3: Control bit 2 (receive enable) at 0 stops frames from being received and clears the overrun flag. Both control bits 0 and 2 must be 1 for reception.
- R4: Control bit 1 selects frames of nine data bits when 1 and eight when 0. Data goes LSB first at 16 ticks per bit. The byte read at address 1 holds data bits 0..7.
- R5: A low pulse on the line that is shorter than half a bit period is ignored and queues nothing.
- R6: With control bits 1 and 3 (address filter) both 1, a frame whose ninth bit is 0 is discarded and a frame whose ninth bit is 1 is queued.
- R7: With the filter off in nine-bit mode, every frame is queued and its ninth bit appears unchanged in status bit 6. In eight-bit mode control bit 3 has no effect and status bit 6 reads 0.
- R8: Status bit 4 is 1 when the frame at the head of the queue had a low stop bit. It returns to 0 once that entry is read and the next frame, which had a valid stop bit, reaches the head.
- R9: A frame that would be queued while the queue holds 2 entries is dropped and sets status bit 5. While bit 5 is 1, no frame is queued. Bit 5 stays 1 until receive enable is cleared.
- R10: The queue returns frames in arrival order. A read at address 1 removes the head entry. `rx_irq` and status bit 7 are 1 exactly while the queue is non-empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| baud_tick | input | 1 | One-cycle pulse at 16 times the bit rate |
| rx_in | input | 1 | Serial line, idle high |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (pops the queue at address 1) |
| reg_addr | input | 1 | 0 = control/status, 1 = data |
| reg_wdata | input | 4 | Control bits: 0 port enable, 1 nine-bit, 2 receive enable, 3 address filter |
| reg_rdata | output | 8 | Status (bits 3:0 control, 4 framing, 5 overrun, 6 ninth bit, 7 not empty) or head data byte |
| rx_irq | output | 1 | Receive request, high while the queue is non-empty |

## Verification
A table of frames is sent in eight-bit and nine-bit modes, with the filter on and off, ninth bits of 0 and 1, and good and bad stop bits. This separates a frame being queued from being dropped, and shows whether the ninth bit and the framing bit stay attached to their own entry. Directed sequences then fill the queue past capacity, which shows that the overrun flag freezes the queue and that only receive enable releases it. Further sequences send a short glitch, disable the port or the receiver, and send a bad frame followed by a good one, to check that the framing flag follows the head entry.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;
  localparam int unsigned BYTE_W    = 8;
  localparam int unsigned WORD_W    = BYTE_W + 1;
  localparam int unsigned CTRL_W    = 4;
  localparam logic        ADDR_CTRL = 1'b0;
  localparam logic        ADDR_DATA = 1'b1;

  typedef struct packed {
    logic addr_filt;
    logic rx_en;
    logic wide9;
    logic port_en;
  } ctrl_t;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_STOP
  } rx_state_e;
endpackage

// File: rtl/uart_rx_sync.sv
module uart_rx_sync #(
  parameter int unsigned STAGES    = 2,
  parameter logic        RESET_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] stg_q;
  logic [STAGES-1:0] stg_d;

  always_comb begin
    stg_d = {stg_q[STAGES-2:0], d};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg_q <= {STAGES{RESET_VAL}};
    else        stg_q <= stg_d;
  end

  assign q = stg_q[STAGES-1];
endmodule

// File: rtl/uart_rx_deframer.sv
module uart_rx_deframer
  import uart_rx_pkg::*;
#(
  parameter int unsigned OVS = 16,
  parameter int unsigned W   = WORD_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         tick,
  input  logic         rx,
  input  logic         wide,
  output logic         done,
  output logic [W-1:0] word,
  output logic         stop_ok
);
  localparam int unsigned CW  = $clog2(OVS);
  localparam int unsigned BW  = $clog2(W + 1);
  localparam int unsigned MID = OVS / 2;

  rx_state_e      state_q, state_d;
  logic [CW-1:0]  cnt_q, cnt_d;
  logic [BW-1:0]  bit_q, bit_d;
  logic [W-1:0]   sh_q, sh_d;
  logic [1:0]     smp_q, smp_d;
  logic           done_q, done_d;
  logic           stop_q, stop_d;
  logic           maj;
  logic           at_vote, at_end;
  logic [BW-1:0]  nbits;

  assign maj     = (smp_q[0] & smp_q[1]) | (smp_q[0] & rx) | (smp_q[1] & rx);
  assign at_vote = (cnt_q == CW'(MID + 1));
  assign at_end  = (cnt_q == CW'(OVS - 1));
  assign nbits   = wide ? BW'(W) : BW'(W - 1);

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    bit_d   = bit_q;
    sh_d    = sh_q;
    smp_d   = smp_q;
    done_d  = 1'b0;
    stop_d  = stop_q;
    if (tick) begin
      if (state_q == ST_IDLE) begin
        if (!rx) begin
          state_d = ST_START;
          cnt_d   = '0;
        end
      end else begin
        cnt_d = at_end ? '0 : cnt_q + 1'b1;
        if (cnt_q == CW'(MID - 1)) smp_d[0] = rx;
        if (cnt_q == CW'(MID))     smp_d[1] = rx;
        case (state_q)
          ST_START: begin
            if (at_vote && maj) state_d = ST_IDLE;
            else if (at_end) begin
              state_d = ST_DATA;
              bit_d   = '0;
            end
          end
          ST_DATA: begin
            if (at_vote) sh_d = {maj, sh_q[W-1:1]};
            if (at_end) begin
              if (bit_q == nbits - 1'b1) state_d = ST_STOP;
              else                       bit_d   = bit_q + 1'b1;
            end
          end
          ST_STOP: begin
            if (at_vote) begin
              done_d  = 1'b1;
              stop_d  = maj;
              state_d = ST_IDLE;
            end
          end
          default: state_d = ST_IDLE;
        endcase
      end
    end
    if (clr) begin
      state_d = ST_IDLE;
      cnt_d   = '0;
      done_d  = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      bit_q   <= '0;
      sh_q    <= '0;
      smp_q   <= '0;
      done_q  <= 1'b0;
      stop_q  <= 1'b1;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      bit_q   <= bit_d;
      sh_q    <= sh_d;
      smp_q   <= smp_d;
      done_q  <= done_d;
      stop_q  <= stop_d;
    end
  end

  assign done    = done_q;
  assign stop_ok = stop_q;
  assign word    = wide ? sh_q : {1'b0, sh_q[W-1:1]};
endmodule

// File: rtl/uart_rx_fifo.sv
module uart_rx_fifo #(
  parameter int unsigned W     = 10,
  parameter int unsigned DEPTH = 2
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       clr,
  input  logic                       push,
  input  logic                       pop,
  input  logic [W-1:0]               din,
  output logic [W-1:0]               dout,
  output logic [$clog2(DEPTH+1)-1:0] count,
  output logic                       full,
  output logic                       empty
);
  localparam int unsigned AW  = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CNW = $clog2(DEPTH + 1);

  logic [W-1:0]   mem_q [DEPTH];
  logic [AW-1:0]  wp_q, wp_d, rp_q, rp_d;
  logic [CNW-1:0] cnt_q, cnt_d;
  logic           do_push, do_pop;

  assign full    = (cnt_q == CNW'(DEPTH));
  assign empty   = (cnt_q == '0);
  assign do_push = push & ~full;
  assign do_pop  = pop & ~empty;

  always_comb begin
    wp_d  = wp_q;
    rp_d  = rp_q;
    cnt_d = cnt_q;
    if (do_push) wp_d = (wp_q == AW'(DEPTH - 1)) ? '0 : wp_q + 1'b1;
    if (do_pop)  rp_d = (rp_q == AW'(DEPTH - 1)) ? '0 : rp_q + 1'b1;
    case ({do_push, do_pop})
      2'b10:   cnt_d = cnt_q + 1'b1;
      2'b01:   cnt_d = cnt_q - 1'b1;
      default: cnt_d = cnt_q;
    endcase
    if (clr) begin
      wp_d  = '0;
      rp_d  = '0;
      cnt_d = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      wp_q  <= wp_d;
      rp_q  <= rp_d;
      cnt_q <= cnt_d;
    end
  end

  for (genvar e = 0; e < DEPTH; e++) begin : g_entry
    logic wen;
    assign wen = do_push & ~clr & (wp_q == AW'(e));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   mem_q[e] <= '0;
      else if (wen) mem_q[e] <= din;
    end
  end

  assign dout  = mem_q[rp_q];
  assign count = cnt_q;
endmodule

// File: rtl/uart_rx_addr.sv
module uart_rx_addr
  import uart_rx_pkg::*;
#(
  parameter int unsigned OVS        = 16,
  parameter int unsigned FIFO_DEPTH = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              baud_tick,
  input  logic              rx_in,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic              reg_addr,
  input  logic [CTRL_W-1:0] reg_wdata,
  output logic [BYTE_W-1:0] reg_rdata,
  output logic              rx_irq
);
  localparam int unsigned ENT_W = WORD_W + 1;
  localparam int unsigned CNW   = $clog2(FIFO_DEPTH + 1);

  logic              rst_s_n;
  logic              rx_s;
  ctrl_t             ctrl_q, ctrl_d;
  logic              ovr_q, ovr_d;
  logic              port_en, rx_en, run;
  logic              frm_done, frm_stop_ok;
  logic [WORD_W-1:0] frm_word;
  logic              accept, push, pop;
  logic [ENT_W-1:0]  head;
  logic [CNW-1:0]    fifo_cnt;
  logic              fifo_full, fifo_empty;

  uart_rx_sync #(.STAGES(2), .RESET_VAL(1'b0)) u_rst_sync (
    .clk(clk), .rst_n(rst_n), .d(1'b1), .q(rst_s_n)
  );

  uart_rx_sync #(.STAGES(2), .RESET_VAL(1'b1)) u_rx_sync (
    .clk(clk), .rst_n(rst_s_n), .d(rx_in), .q(rx_s)
  );

  assign port_en = ctrl_q.port_en;
  assign rx_en   = ctrl_q.rx_en;
  assign run     = port_en & rx_en;

  uart_rx_deframer #(.OVS(OVS), .W(WORD_W)) u_deframer (
    .clk(clk), .rst_n(rst_s_n), .clr(~run), .tick(baud_tick), .rx(rx_s),
    .wide(ctrl_q.wide9), .done(frm_done), .word(frm_word), .stop_ok(frm_stop_ok)
  );

  always_comb begin
    accept = frm_done & run & ~ovr_q;
    if (ctrl_q.wide9 && ctrl_q.addr_filt && !frm_word[WORD_W-1]) accept = 1'b0;
  end

  assign push = accept & ~fifo_full;
  assign pop  = reg_rd & (reg_addr == ADDR_DATA) & ~fifo_empty;

  uart_rx_fifo #(.W(ENT_W), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_s_n), .clr(~port_en), .push(push), .pop(pop),
    .din({~frm_stop_ok, frm_word}), .dout(head), .count(fifo_cnt),
    .full(fifo_full), .empty(fifo_empty)
  );

  always_comb begin
    ctrl_d = ctrl_q;
    if (reg_wr && reg_addr == ADDR_CTRL) ctrl_d = ctrl_t'(reg_wdata);
  end

  always_comb begin
    ovr_d = ovr_q;
    if (!run)                     ovr_d = 1'b0;
    else if (accept && fifo_full) ovr_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      ctrl_q <= '0;
      ovr_q  <= 1'b0;
    end else begin
      ctrl_q <= ctrl_d;
      ovr_q  <= ovr_d;
    end
  end

  always_comb begin
    if (reg_addr == ADDR_DATA)
      reg_rdata = head[BYTE_W-1:0];
    else
      reg_rdata = {~fifo_empty, head[WORD_W-1] & ~fifo_empty, ovr_q,
                   head[ENT_W-1] & ~fifo_empty, ctrl_q};
  end

  assign rx_irq = ~fifo_empty;
endmodule

// File: rtl/uart_rx_addr_chk.sv
module uart_rx_addr_chk #(
  parameter int unsigned DEPTH = 2,
  parameter int unsigned CNW   = 2
) (
  input logic           clk,
  input logic           rst_n,
  input logic           port_en,
  input logic           rx_en,
  input logic           ovr,
  input logic           push,
  input logic           pop,
  input logic           irq,
  input logic [CNW-1:0] cnt
);
  // R10
  fifo_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CNW'(DEPTH));

  // R10
  irq_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !pop && port_en) |=> irq);

  // R10
  pop_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !push && port_en) |=> (cnt == $past(cnt) - 1'b1));

  // R9
  ovr_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ovr && rx_en && port_en) |=> ovr);

  // R9
  ovr_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovr |-> !push);

  // R2
  port_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !port_en |=> (cnt == '0) && !ovr);

  // R3
  rxen_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_en |=> !ovr);
endmodule

bind uart_rx_addr uart_rx_addr_chk #(.DEPTH(FIFO_DEPTH), .CNW(CNW)) u_chk (
  .clk(clk), .rst_n(rst_s_n), .port_en(port_en), .rx_en(rx_en), .ovr(ovr_q),
  .push(push), .pop(pop), .irq(rx_irq), .cnt(fifo_cnt)
);

// File: tb/uart_rx_addr_tb.sv
module uart_rx_addr_tb;
  localparam int CLK_PERIOD = 10;
  localparam int TICK_DIV   = 4;
  localparam int BIT_CLKS   = 16 * TICK_DIV;
  localparam int NVEC       = 8;
  // {wide9, filter, stop_ok, accept, data9}
  localparam logic [12:0] VEC [NVEC] = '{
    {1'b0, 1'b0, 1'b1, 1'b1, 9'h0A5},
    {1'b0, 1'b1, 1'b1, 1'b1, 9'h03C},
    {1'b1, 1'b0, 1'b1, 1'b1, 9'h15A},
    {1'b1, 1'b0, 1'b1, 1'b1, 9'h081},
    {1'b1, 1'b1, 1'b1, 1'b1, 9'h142},
    {1'b1, 1'b1, 1'b1, 1'b0, 9'h077},
    {1'b0, 1'b0, 1'b0, 1'b1, 9'h00F},
    {1'b1, 1'b0, 1'b0, 1'b1, 9'h1FF}
  };

  logic       clk, rst_n, baud_tick, rx_in, reg_wr, reg_rd, reg_addr;
  logic [3:0] reg_wdata;
  logic [7:0] reg_rdata;
  logic       rx_irq;
  int         checks, errors, cyc, tdiv;
  bit         finished;

  uart_rx_addr u_dut (
    .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick), .rx_in(rx_in),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .rx_irq(rx_irq)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  always @(posedge clk) begin
    tdiv      <= (tdiv == TICK_DIV - 1) ? 0 : tdiv + 1;
    baud_tick <= (tdiv == TICK_DIV - 1);
    cyc       <= cyc + 1;
    if (cyc > 150000 && !finished) begin
      finished = 1'b1;
      errors   = errors + 1;
      $display("FAIL watchdog: actual=%0d cycles expected=<150000", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr_ctrl(input logic [3:0] v);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = 1'b0; reg_wdata = v;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic a, output logic [7:0] v);
    @(negedge clk);
    reg_rd = 1'b1; reg_addr = a;
    #1 v = reg_rdata;
    @(negedge clk);
    reg_rd = 1'b0; reg_addr = 1'b0;
  endtask

  task automatic hold(input logic lvl, input int clks);
    rx_in = lvl;
    repeat (clks) @(negedge clk);
  endtask

  task automatic send(input logic [8:0] d, input bit nine, input bit stop);
    @(negedge clk);
    hold(1'b0, BIT_CLKS);
    for (int b = 0; b < (nine ? 9 : 8); b++) hold(d[b], BIT_CLKS);
    hold(stop, BIT_CLKS);
    hold(1'b1, 2 * BIT_CLKS);
  endtask

  logic [7:0] v;

  initial begin
    checks = 0; errors = 0; cyc = 0; tdiv = 0; finished = 1'b0;
    baud_tick = 1'b0; rx_in = 1'b1; reg_wr = 1'b0; reg_rd = 1'b0;
    reg_addr = 1'b0; reg_wdata = '0; rst_n = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // R1 reset state
    check("R1 irq", rx_irq, 0);
    rd(1'b0, v);
    check("R1 status", v, 8'h00);

    // table walk: R4 R6 R7 R8
    for (int i = 0; i < NVEC; i++) begin
      logic w9, flt, sok, acc;
      logic [8:0] d;
      {w9, flt, sok, acc, d} = VEC[i];
      wr_ctrl({flt, 1'b1, w9, 1'b1});
      send(d, w9, sok);
      check($sformatf("R6 accept vec%0d", i), rx_irq, acc);
      if (acc) begin
        rd(1'b0, v);
        check($sformatf("R7 ninth vec%0d", i), v[6], w9 ? d[8] : 1'b0);
        check($sformatf("R8 ferr vec%0d", i), v[4], !sok);
        rd(1'b1, v);
        check($sformatf("R4 data vec%0d", i), v, d[7:0]);
        check($sformatf("R10 empty vec%0d", i), rx_irq, 0);
      end
    end

    // R5 glitch rejection
    wr_ctrl(4'b0101);
    @(negedge clk);
    hold(1'b0, 4 * TICK_DIV);
    hold(1'b1, 2 * BIT_CLKS);
    check("R5 glitch", rx_irq, 0);
    send(9'h066, 1'b0, 1'b1);
    rd(1'b1, v);
    check("R5 after glitch", v, 8'h66);

    // R2 port disabled
    wr_ctrl(4'b0100);
    send(9'h011, 1'b0, 1'b1);
    check("R2 port off", rx_irq, 0);

    // R3 receive disabled
    wr_ctrl(4'b0001);
    send(9'h022, 1'b0, 1'b1);
    check("R3 rx off", rx_irq, 0);

    // R9 R10 overrun and order
    wr_ctrl(4'b0101);
    send(9'h0A1, 1'b0, 1'b1);
    send(9'h0B2, 1'b0, 1'b1);
    rd(1'b0, v);
    check("R9 no ovr yet", v[5], 0);
    send(9'h0C3, 1'b0, 1'b1);
    rd(1'b0, v);
    check("R9 ovr set", v[5], 1);
    check("R10 nonempty", v[7], 1);
    rd(1'b1, v);
    check("R10 order 1", v, 8'hA1);
    send(9'h0D4, 1'b0, 1'b1);
    rd(1'b0, v);
    check("R9 ovr sticky", v[5], 1);
    rd(1'b1, v);
    check("R10 order 2", v, 8'hB2);
    check("R9 frozen", rx_irq, 0);
    wr_ctrl(4'b0001);
    wr_ctrl(4'b0101);
    rd(1'b0, v);
    check("R9 ovr cleared", v[5], 0);
    send(9'h0E5, 1'b0, 1'b1);
    rd(1'b1, v);
    check("R9 resumes", v, 8'hE5);

    // R8 framing flag follows head entry
    send(9'h033, 1'b0, 1'b0);
    send(9'h044, 1'b0, 1'b1);
    rd(1'b0, v);
    check("R8 ferr head", v[4], 1);
    rd(1'b1, v);
    rd(1'b0, v);
    check("R8 ferr cleared", v[4], 0);
    rd(1'b1, v);
    check("R8 good data", v, 8'h44);

    // R2 port disable flushes queue
    send(9'h055, 1'b0, 1'b1);
    check("R2 queued", rx_irq, 1);
    wr_ctrl(4'b0100);
    @(negedge clk);
    check("R2 flushed", rx_irq, 0);

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule